// File: doc/BRIEF.md
# External Pin Interrupt Edge Detector

This block watches a single external interrupt pin and turns qualified transitions on it into a sticky interrupt request. The raw pin is first brought into the clock domain. A transition is accepted only after the new level has stayed put for a minimum number of system clocks, which rejects glitches and short pulses. A 4-bit control register decides whether the pin is monitored at all, which polarity is active, whether one edge or both edges count, and whether an accepted edge should also emit a start pulse towards a neighbouring timer.

Software reaches the control register through a simple write strobe with write data and a continuously driven read data bus. The request flag can be cleared in two ways. The interrupt acknowledge clears it. A test-and-clear strobe also clears it, and reports the flag's prior value one cycle later as a skip indication. The interrupt output is raised while the flag, a local enable and a global enable are all set. A level-test output reports whether the filtered pin sits at the selected polarity. A control write that changes the enable or polarity bits can itself raise the flag.

Top module: `pinint_top`

## Requirements
- R1: After reset the control register reads 4'b0000, and req_flag_o, irq_o, skip_o, tmr_start_o and level_hit_o are all 0.
- R2: A write with cfg_we_i=1 loads cfg_wdata_i into the control register. cfg_rdata_i shows the new value after that clock edge. Bit 3 is the pin enable, bit 2 the polarity (1 = rising/high), bit 1 the dual-edge select, and bit 0 the timer-start select.
- R3: A pin level is accepted only when it differs from the last accepted level for STABLE_CYCLES (default 4) consecutive synchronised samples. A pulse that is held for fewer clocks is ignored. For a held level, req_flag_o rises after the sixth rising clock edge that samples the new pin level (two synchroniser stages plus four stable samples).
- R4: While control bit 3 is 0, no pin transition sets the flag, and level_hit_o stays 0.
- R5: With bit 3 = 1 and bit 1 = 0, only the edge selected by bit 2 sets the flag: a falling edge when bit 2 = 0, a rising edge when bit 2 = 1.
- R6: With bit 3 = 1 and bit 1 = 1, both rising and falling accepted edges set the flag, whatever bit 2 holds.
- R7: level_hit_o is 1 exactly when bit 3 = 1 and the accepted pin level equals bit 2 (low when bit 2 = 0, high when bit 2 = 1).
- R8: When bit 0 = 1, an edge that sets the flag also gives a one-cycle tmr_start_o pulse, in the same cycle that the flag first reads 1. When bit 0 = 0, tmr_start_o stays 0.
- R9: irq_o equals req_flag_o AND local_en_i AND global_en_i.
- R10: int_ack_i or test_clr_i clears the flag at the next edge. When test_clr_i is high, skip_o shows for one cycle after that edge the flag value from before the edge.
- R11: If a set event and a clear in the same cycle coincide, the flag ends up set.
- R12: A write that changes bit 2 or bit 3, where the new bit 3 = 1 and the accepted pin level equals the new bit 2, sets the flag. A write that changes only bits 0 or 1 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw external interrupt pin |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 4 | Control register write data |
| cfg_rdata_o | output | 4 | Control register read data |
| test_clr_i | input | 1 | Test-and-clear strobe for the request flag |
| skip_o | output | 1 | Flag value before the test-and-clear, valid for one cycle |
| int_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| local_en_i | input | 1 | Local interrupt enable |
| global_en_i | input | 1 | Global interrupt enable |
| req_flag_o | output | 1 | Sticky request flag |
| irq_o | output | 1 | Interrupt request |
| level_hit_o | output | 1 | Filtered pin is at the selected polarity |
| tmr_start_o | output | 1 | Timer count-start pulse |

## Verification
A stuck or miscounting stability counter shows as a flag that rises one or more cycles early or late, or that is set by a three-clock pulse. A wrong accepted level appears at once on level_hit_o, and at the next edge it makes the wrong polarity set the flag. A flag whose priority or clear logic is wrong shows on req_flag_o and skip_o one edge after the offending acknowledge or test strobe. A bad write comparison shows one edge after the write, as a flag that is raised or missing. The bench therefore compares every output on every cycle against its own model.

// File: rtl/pinint_pkg.sv
package pinint_pkg;

  typedef struct packed {
    logic pin_en;      // bit 3
    logic pol_high;    // bit 2
    logic both_edges;  // bit 1
    logic tmr_sync;    // bit 0
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '0;

  // An accepted transition to new_lvl qualifies as an event under cfg.
  function automatic logic edge_counts(input pin_cfg_t cfg, input logic new_lvl);
    return cfg.pin_en && (cfg.both_edges || (new_lvl == cfg.pol_high));
  endfunction

  // Level test: filtered level sits at the selected polarity.
  function automatic logic level_matches(input pin_cfg_t cfg, input logic lvl);
    return cfg.pin_en && (lvl == cfg.pol_high);
  endfunction

  // A control write that touches enable/polarity and lands on the active level.
  function automatic logic write_arms(input pin_cfg_t old_cfg, input pin_cfg_t new_cfg,
                                      input logic lvl);
    logic touched;
    touched = (old_cfg.pin_en != new_cfg.pin_en) || (old_cfg.pol_high != new_cfg.pol_high);
    return touched && new_cfg.pin_en && (lvl == new_cfg.pol_high);
  endfunction

endpackage

// File: rtl/pinint_sync.sv
module pinint_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pinint_filter.sv
module pinint_filter #(
  parameter int   STABLE_CYCLES = 4,
  parameter logic IDLE_LEVEL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,      // synchronised pin
  output logic lvl_o,      // last accepted level
  output logic accept_o,   // this edge accepts lvl_i
  output logic new_lvl_o   // level being accepted
);
  localparam int CW = (STABLE_CYCLES > 2) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [CW-1:0] run_q;
  logic          acc_q;
  logic          differs;

  assign differs   = (lvl_i != acc_q);
  assign accept_o  = differs && (run_q == LAST);
  assign new_lvl_o = lvl_i;
  assign lvl_o     = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      acc_q <= IDLE_LEVEL;
    end else if (!differs) begin
      run_q <= '0;
    end else if (accept_o) begin
      run_q <= '0;
      acc_q <= lvl_i;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/pinint_flag.sv
module pinint_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic test_i,
  output logic flag_o,
  output logic skip_o
);
  logic flag_q, skip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      skip_q <= test_i && flag_q;
      if (set_i)                flag_q <= 1'b1;  // set wins
      else if (ack_i || test_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign skip_o = skip_q;
endmodule

// File: rtl/pinint_top.sv
module pinint_top
  import pinint_pkg::*;
#(
  parameter int   SYNC_STAGES   = 2,
  parameter int   STABLE_CYCLES = 4,
  parameter logic IDLE_LEVEL    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       cfg_we_i,
  input  logic [3:0] cfg_wdata_i,
  output logic [3:0] cfg_rdata_o,
  input  logic       test_clr_i,
  output logic       skip_o,
  input  logic       int_ack_i,
  input  logic       local_en_i,
  input  logic       global_en_i,
  output logic       req_flag_o,
  output logic       irq_o,
  output logic       level_hit_o,
  output logic       tmr_start_o
);
  pin_cfg_t cfg_q, cfg_new;
  logic     pin_sync;
  logic     acc_lvl, accept_evt, new_lvl;
  logic     edge_evt, write_evt, set_evt, clr_evt;
  logic     tmr_q;

  pinint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  pinint_filter #(.STABLE_CYCLES(STABLE_CYCLES), .IDLE_LEVEL(IDLE_LEVEL)) u_filt (
    .clk(clk), .rst_n(rst_n), .lvl_i(pin_sync),
    .lvl_o(acc_lvl), .accept_o(accept_evt), .new_lvl_o(new_lvl)
  );

  assign cfg_new   = pin_cfg_t'(cfg_wdata_i);
  assign edge_evt  = accept_evt && edge_counts(cfg_q, new_lvl);
  assign write_evt = cfg_we_i && write_arms(cfg_q, cfg_new, acc_lvl);
  assign set_evt   = edge_evt || write_evt;
  assign clr_evt   = int_ack_i || test_clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      tmr_q <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_new;
      tmr_q <= edge_evt && cfg_q.tmr_sync;
    end
  end

  pinint_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(set_evt), .ack_i(int_ack_i),
    .test_i(test_clr_i), .flag_o(req_flag_o), .skip_o(skip_o)
  );

  assign cfg_rdata_o = cfg_q;
  assign irq_o       = req_flag_o && local_en_i && global_en_i;
  assign level_hit_o = level_matches(cfg_q, acc_lvl);
  assign tmr_start_o = tmr_q;
endmodule

// File: rtl/pinint_chk.sv
module pinint_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we_i,
  input logic [3:0] cfg_wdata_i,
  input logic [3:0] cfg_rdata_o,
  input logic       test_clr_i,
  input logic       skip_o,
  input logic       int_ack_i,
  input logic       local_en_i,
  input logic       global_en_i,
  input logic       req_flag_o,
  input logic       irq_o,
  input logic       level_hit_o,
  input logic       tmr_start_o,
  input logic       set_evt,
  input logic       clr_evt
);
  a_r9_no_irq_without_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (!local_en_i || !global_en_i) |-> !irq_o);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> req_flag_o);

  a_r10_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !req_flag_o);

  a_r10_skip_reports_prior: assert property (@(posedge clk) disable iff (!rst_n)
    test_clr_i |=> (skip_o == $past(req_flag_o)));

  a_r10_skip_needs_test: assert property (@(posedge clk) disable iff (!rst_n)
    !test_clr_i |=> !skip_o);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> req_flag_o);

  a_r4_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_flag_o) |-> ($past(cfg_rdata_o[3]) || $past(cfg_we_i && cfg_wdata_i[3])));

  a_r8_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start_o |-> req_flag_o);

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start_o |=> !tmr_start_o);

  a_r7_level_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    level_hit_o |-> cfg_rdata_o[3]);

  a_r2_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we_i |=> $stable(cfg_rdata_o));
endmodule

bind pinint_top pinint_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o), .test_clr_i(test_clr_i), .skip_o(skip_o),
  .int_ack_i(int_ack_i), .local_en_i(local_en_i), .global_en_i(global_en_i),
  .req_flag_o(req_flag_o), .irq_o(irq_o), .level_hit_o(level_hit_o),
  .tmr_start_o(tmr_start_o), .set_evt(set_evt), .clr_evt(clr_evt)
);

// File: tb/tb_pinint_top.sv
`timescale 1ns/1ps
module tb_pinint_top;
  localparam int STABLE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = 4'h0;
  logic [3:0] cfg_rdata;
  logic       test_clr = 1'b0, skip;
  logic       int_ack = 1'b0;
  logic       local_en = 1'b0, global_en = 1'b0;
  logic       req_flag, irq, level_hit, tmr_start;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pinint_top dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .test_clr_i(test_clr), .skip_o(skip), .int_ack_i(int_ack),
    .local_en_i(local_en), .global_en_i(global_en), .req_flag_o(req_flag), .irq_o(irq),
    .level_hit_o(level_hit), .tmr_start_o(tmr_start)
  );

  // reference state, derived from the requirements
  logic m_s1, m_s2, m_acc, m_flag, m_skip, m_tmr;
  logic [3:0] m_cfg;
  int m_run;

  function automatic logic ref_edge(input logic [3:0] c, input logic nl);
    if (!c[3]) return 1'b0;
    if (c[1])  return 1'b1;
    return nl == c[2];
  endfunction

  function automatic logic ref_wset(input logic [3:0] o, input logic [3:0] n, input logic lvl);
    return (o[3:2] != n[3:2]) && n[3] && (lvl == n[2]);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = 1'b1; m_s2 = 1'b1; m_acc = 1'b1; m_flag = 0; m_skip = 0; m_tmr = 0;
    m_cfg = 4'h0; m_run = 0;
  endtask

  task automatic compare_all(input string tag);
    chk(req_flag, m_flag, {tag, " R3 flag"});
    chk(irq, m_flag && local_en && global_en, {tag, " R9 irq"});
    chk(level_hit, m_cfg[3] && (m_acc == m_cfg[2]), {tag, " R7 level"});
    chk(skip, m_skip, {tag, " R10 skip"});
    chk(tmr_start, m_tmr, {tag, " R8 tmr"});
    checks++;
    if (cfg_rdata !== m_cfg) begin
      errors++;
      $display("FAIL %s R2 cfg: actual=%h expected=%h", tag, cfg_rdata, m_cfg);
    end
  endtask

  task automatic tick(input string tag);
    logic acc_ev, qual, wset;
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      acc_ev = (m_s2 != m_acc) && (m_run == STABLE - 1);
      qual   = acc_ev && ref_edge(m_cfg, m_s2);
      wset   = cfg_we && ref_wset(m_cfg, cfg_wdata, m_acc);
      m_skip = test_clr && m_flag;
      if (qual || wset)           m_flag = 1'b1;
      else if (int_ack || test_clr) m_flag = 1'b0;
      m_tmr = qual && m_cfg[0];
      if (cfg_we) m_cfg = cfg_wdata;
      if (m_s2 == m_acc) m_run = 0;
      else if (acc_ev) begin m_acc = m_s2; m_run = 0; end
      else m_run++;
      m_s2 = m_s1;
      m_s1 = pin;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic wr(input logic [3:0] v, input string tag);
    cfg_we = 1'b1; cfg_wdata = v;
    tick(tag);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(200_000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    model_reset();
    @(negedge clk);
    run(3, "reset");
    rst_n = 1'b1;
    // R1: reset values
    chk(req_flag, 1'b0, "R1 flag"); chk(skip, 1'b0, "R1 skip");
    chk(tmr_start, 1'b0, "R1 tmr"); chk(level_hit, 1'b0, "R1 level");
    chk(cfg_rdata == 4'h0, 1'b1, "R1 cfg");
    run(3, "R1");

    // R2: enable, falling, single edge
    wr(4'b1000, "R2");
    chk(cfg_rdata == 4'b1000, 1'b1, "R2 readback");
    local_en = 1; global_en = 1;

    // R3: 3-clock low pulse is ignored
    pin = 0; run(3, "R3"); pin = 1; run(8, "R3");
    chk(req_flag, 1'b0, "R3 short pulse ignored");
    // R3/R5: held low -> flag after the 6th edge
    pin = 0;
    run(5, "R3");
    chk(req_flag, 1'b0, "R3 not before sixth edge");
    run(1, "R3");
    chk(req_flag, 1'b1, "R3 falling accepted");
    chk(irq, 1'b1, "R9 irq with enables");
    global_en = 0; #1; chk(irq, 1'b0, "R9 global off"); global_en = 1;

    // R10: test-and-clear
    test_clr = 1; tick("R10"); test_clr = 0;
    chk(req_flag, 1'b0, "R10 cleared"); chk(skip, 1'b1, "R10 skip reports");
    tick("R10"); chk(skip, 1'b0, "R10 skip one cycle");

    // R5: rising not counted in falling mode
    pin = 1; run(10, "R5");
    chk(req_flag, 1'b0, "R5 rising ignored");

    // R4: disabled pin
    wr(4'b0000, "R4");
    pin = 0; run(8, "R4"); pin = 1; run(8, "R4");
    chk(req_flag, 1'b0, "R4 disabled"); chk(level_hit, 1'b0, "R4 level off");

    // R6 + R8: both edges with timer sync (pol low, level high: no write set)
    wr(4'b1011, "R12");
    chk(req_flag, 1'b0, "R12 no arm when level mismatches");
    pin = 0; run(6, "R6");
    chk(req_flag, 1'b1, "R6 falling in dual"); chk(tmr_start, 1'b1, "R8 pulse");
    tick("R8"); chk(tmr_start, 1'b0, "R8 one cycle");
    int_ack = 1; tick("R10"); int_ack = 0;
    chk(req_flag, 1'b0, "R10 ack clears");

    // R11: ack held while rising edge accepted
    int_ack = 1; pin = 1; run(6, "R11");
    chk(req_flag, 1'b1, "R11 set wins"); int_ack = 0;
    int_ack = 1; tick("R11"); int_ack = 0;
    chk(req_flag, 1'b0, "R11 later clear");

    // R7 and R12: level high, switch polarity to high -> arm
    chk(level_hit, 1'b0, "R7 pol low at high level");
    wr(4'b1001, "R12");
    chk(req_flag, 1'b0, "R12 bits0/1 only");
    wr(4'b1101, "R12");
    chk(req_flag, 1'b1, "R12 polarity write arms");
    chk(level_hit, 1'b1, "R7 pol high at high level");
    test_clr = 1; tick("R12"); test_clr = 0;

    // random mix
    for (int blk = 0; blk < 600; blk++) begin
      int len;
      if ($urandom_range(0, 3) == 0) pin = ~pin;
      len = $urandom_range(1, 7);
      for (int k = 0; k < len; k++) begin
        cfg_we    = ($urandom_range(0, 19) == 0);
        cfg_wdata = 4'($urandom);
        int_ack   = ($urandom_range(0, 15) == 0);
        test_clr  = ($urandom_range(0, 15) == 0);
        if ($urandom_range(0, 7) == 0) local_en = ~local_en;
        if ($urandom_range(0, 7) == 0) global_en = ~global_en;
        tick("RND");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule